// File: doc/BRIEF.md
# Indirect Configuration and Port-Space Access Window

This block lets a processor-side register bus reach configuration space and I/O-port space on a downstream peripheral bus without mapping either space directly. Software first loads a target address into an address register. It then reads or writes a byte, halfword or word through one of two data windows. One window starts a configuration cycle and the other starts a port-space cycle. Each window access becomes one downstream request that carries the cycle kind, the address, the byte enables and the lane-placed write data. The register bus is held in wait until the matching response comes back. Read data is then returned right-justified.

For configuration cycles, the stored address holds a bus number in bits 23:16, a device/function code in bits 15:8 and a register offset in bits 7:0. The two lowest offset bits are always sent as zero, and the byte lane is chosen by the low bits of the window offset that software used. For port cycles, the stored address is a 16-bit port number, and the lane comes from that number's own low bits. A host may issue a harmless configuration read, with the register byte cleared, just before a configuration write. The block serves that read like any other and leaves the stored address unchanged. When the kind of cycle changes between two requests, the block inserts idle cycles first, so that the downstream side never starts a new kind of cycle one cycle too early.

Top module: `cfgio_window`

## Requirements
- R1: After reset, rb_ready and dn_req_valid are 0, and the stored address reads back as 0.
- R2: A write at offset 0x064 stores rb_wdata as the target address. A read there returns it. Either access completes with rb_ready one cycle after acceptance and issues no downstream request.
- R3: An access with rb_addr[11:2] equal to 0x068>>2 issues dn_req_is_cfg=1 with dn_req_addr = {8'h00, A[23:2], 2'b00}, where A is the stored address.
- R4: An access with rb_addr[11:2] equal to 0x06C>>2 issues dn_req_is_cfg=0 with dn_req_addr = {16'h0000, A[15:0]}.
- R5: rb_size 0 is a byte, 1 a halfword, and 2 or 3 a word. The lane is off[1:0] for a byte, {off[1],0} for a halfword and 0 for a word. dn_req_be is 1<<lane, 3<<lane or 4'hF. For configuration cycles, off is rb_addr[1:0].
- R6: For port cycles, off is A[1:0], and the low two bits of rb_addr are ignored.
- R7: For writes, dn_req_write=1 and dn_req_wdata equals (rb_wdata masked to the access size) shifted left by 8*lane bits.
- R8: A read returns rb_rdata = (dn_rsp_rdata >> 8*lane) masked to the access size, zero-extended. A window write returns 0.
- R9: dn_req_valid is a one-cycle pulse. rb_ready stays 0 until dn_rsp_valid is seen, then pulses for one cycle on the following cycle.
- R10: Window accesses made without a new address write use the last stored address.
- R11: A configuration read issued with the register byte cleared, followed by an address write and a configuration write, leaves the final request carrying the full new address.
- R12: When a request's cycle kind differs from that of the previous request since reset, dn_req_valid rises TURN_CYCLES cycles later than usual. The first request after reset and requests of the same kind are not delayed.
- R13: An access at any other offset completes one cycle after acceptance, reads 0 and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rb_valid | input | 1 | Register-bus access request, held until rb_ready |
| rb_write | input | 1 | 1 = write, 0 = read |
| rb_addr | input | 12 | Register-bus byte offset |
| rb_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| rb_wdata | input | 32 | Right-justified write data |
| rb_ready | output | 1 | One-cycle completion strobe |
| rb_rdata | output | 32 | Right-justified read data, valid with rb_ready |
| dn_req_valid | output | 1 | One-cycle downstream request strobe |
| dn_req_is_cfg | output | 1 | 1 = configuration cycle, 0 = port cycle |
| dn_req_write | output | 1 | Request direction |
| dn_req_addr | output | 32 | Request address |
| dn_req_be | output | 4 | Byte enables |
| dn_req_wdata | output | 32 | Lane-placed write data |
| dn_rsp_valid | input | 1 | Response strobe |
| dn_rsp_rdata | input | 32 | Response data in bus lanes |

## Verification
The configuration window is swept over every size, every window offset and both directions. A stored address with nonzero upper bits and nonzero low offset bits is used, so the sweep can tell whether the address is masked and where the lane comes from. The port window is swept over every low port-address bit and size, and each access uses a deliberately mismatched window offset; a design that takes the lane from the wrong source fails this sweep. Because the two sweeps alternate cycle kinds and repeat kinds, the same run measures when each request appears, which separates the turnaround delay from the normal path. Short sequences cover address readback, reuse of the stored address, the dummy-read-then-write order and unmapped offsets.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } win_state_e;

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] size);
        case (size)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/cfgio_lane_decode.sv
module cfgio_lane_decode
    import cfgio_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] offset,
    output logic [LANE_W-1:0] lane,
    output logic [LANES-1:0]  be
);
    always_comb begin
        case (size)
            2'd0: begin
                lane = offset;
                be   = 4'b0001 << offset;
            end
            2'd1: begin
                lane = {offset[1], 1'b0};
                be   = 4'b0011 << {offset[1], 1'b0};
            end
            default: begin
                lane = '0;
                be   = '1;
            end
        endcase
    end
endmodule

// File: rtl/cfgio_wdata_place.sv
module cfgio_wdata_place
    import cfgio_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] placed
);
    always_comb placed = (wdata & size_mask(size)) << {lane, 3'b000};
endmodule

// File: rtl/cfgio_rdata_align.sv
module cfgio_rdata_align
    import cfgio_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] aligned
);
    always_comb aligned = (raw >> {lane, 3'b000}) & size_mask(size);
endmodule

// File: rtl/cfgio_window.sv
module cfgio_window
    import cfgio_pkg::*;
#(
    parameter int          REG_ADDR_W  = 12,
    parameter logic [11:0] ADDR_OFS    = 12'h064,
    parameter logic [11:0] CFG_WIN_OFS = 12'h068,
    parameter logic [11:0] IO_WIN_OFS  = 12'h06C,
    parameter int          TURN_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rb_valid,
    input  logic                  rb_write,
    input  logic [REG_ADDR_W-1:0] rb_addr,
    input  logic [1:0]            rb_size,
    input  logic [31:0]           rb_wdata,
    output logic                  rb_ready,
    output logic [31:0]           rb_rdata,
    output logic                  dn_req_valid,
    output logic                  dn_req_is_cfg,
    output logic                  dn_req_write,
    output logic [31:0]           dn_req_addr,
    output logic [3:0]            dn_req_be,
    output logic [31:0]           dn_req_wdata,
    input  logic                  dn_rsp_valid,
    input  logic [31:0]           dn_rsp_rdata
);
    localparam int GAP_W = (TURN_CYCLES > 1) ? $clog2(TURN_CYCLES) : 1;
    localparam int CHK_W = GAP_W + 2;

    typedef struct packed {
        win_state_e        st;
        logic [31:0]       tgt;
        logic              is_cfg;
        logic              wr;
        logic [1:0]        size;
        logic [LANE_W-1:0] lane;
        logic [LANES-1:0]  be;
        logic [31:0]       wdata;
        logic [31:0]       raddr;
        logic [31:0]       rdata;
        logic [GAP_W-1:0]  gap;
        logic              last_cfg;
        logic              have_last;
    } win_regs_t;

    win_regs_t r_q, r_d;

    logic              hit_tgt, hit_cfg, hit_io;
    logic [LANE_W-1:0] off_w, lane_w;
    logic [LANES-1:0]  be_w;
    logic [31:0]       placed_w, aligned_w;

    assign hit_tgt = rb_addr[REG_ADDR_W-1:2] == ADDR_OFS[REG_ADDR_W-1:2];
    assign hit_cfg = rb_addr[REG_ADDR_W-1:2] == CFG_WIN_OFS[REG_ADDR_W-1:2];
    assign hit_io  = rb_addr[REG_ADDR_W-1:2] == IO_WIN_OFS[REG_ADDR_W-1:2];
    assign off_w   = hit_cfg ? rb_addr[1:0] : r_q.tgt[1:0];

    cfgio_lane_decode i_lane (
        .size   (rb_size),
        .offset (off_w),
        .lane   (lane_w),
        .be     (be_w)
    );

    cfgio_wdata_place i_place (
        .wdata  (rb_wdata),
        .size   (rb_size),
        .lane   (lane_w),
        .placed (placed_w)
    );

    cfgio_rdata_align i_align (
        .raw     (dn_rsp_rdata),
        .size    (r_q.size),
        .lane    (r_q.lane),
        .aligned (aligned_w)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (rb_valid) begin
                    if (hit_cfg || hit_io) begin
                        r_d.is_cfg    = hit_cfg;
                        r_d.wr        = rb_write;
                        r_d.size      = rb_size;
                        r_d.lane      = lane_w;
                        r_d.be        = be_w;
                        r_d.wdata     = rb_write ? placed_w : '0;
                        r_d.raddr     = hit_cfg ? {8'h00, r_q.tgt[23:2], 2'b00}
                                                : {16'h0000, r_q.tgt[15:0]};
                        r_d.last_cfg  = hit_cfg;
                        r_d.have_last = 1'b1;
                        if (TURN_CYCLES > 0 && r_q.have_last && (r_q.last_cfg != hit_cfg)) begin
                            r_d.st  = ST_GAP;
                            r_d.gap = GAP_W'(TURN_CYCLES - 1);
                        end else begin
                            r_d.st = ST_REQ;
                        end
                    end else begin
                        r_d.rdata = '0;
                        if (hit_tgt) begin
                            if (rb_write) r_d.tgt = rb_wdata;
                            else          r_d.rdata = r_q.tgt;
                        end
                        r_d.st = ST_DONE;
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gap == '0) r_d.st = ST_REQ;
                else               r_d.gap = r_q.gap - 1'b1;
            end
            ST_REQ: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (dn_rsp_valid) begin
                    r_d.rdata = r_q.wr ? '0 : aligned_w;
                    r_d.st    = ST_DONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign rb_ready      = r_q.st == ST_DONE;
    assign rb_rdata      = r_q.rdata;
    assign dn_req_valid  = r_q.st == ST_REQ;
    assign dn_req_is_cfg = r_q.is_cfg;
    assign dn_req_write  = r_q.wr;
    assign dn_req_addr   = r_q.raddr;
    assign dn_req_be     = r_q.be;
    assign dn_req_wdata  = r_q.wdata;

    // Independent tracking for the turnaround check
    logic [CHK_W-1:0] since_acc_q;
    logic             chk_prev_cfg_q, chk_have_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc_q    <= '0;
            chk_prev_cfg_q <= 1'b0;
            chk_have_q     <= 1'b0;
        end else begin
            if (r_q.st == ST_IDLE && rb_valid)         since_acc_q <= '0;
            else if (since_acc_q != {CHK_W{1'b1}})     since_acc_q <= since_acc_q + 1'b1;
            if (dn_req_valid) begin
                chk_prev_cfg_q <= dn_req_is_cfg;
                chk_have_q     <= 1'b1;
            end
        end
    end

    // R12
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && chk_have_q && (chk_prev_cfg_q != dn_req_is_cfg))
            |-> (since_acc_q >= CHK_W'(TURN_CYCLES)));

    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |=> !dn_req_valid);

    // R9
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && !dn_rsp_valid) |=> !rb_ready);

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_ready |=> !rb_ready);

    // R5
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> ($countones(dn_req_be) == 1 || dn_req_be == 4'h3 ||
                          dn_req_be == 4'hC || dn_req_be == 4'hF));

    // R3
    cfg_addr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_is_cfg) |-> (dn_req_addr[1:0] == 2'b00 && dn_req_addr[31:24] == 8'h00));
endmodule

// File: tb/test_cfgio_window.sv
module test_cfgio_window;
    localparam time CLK_PERIOD = 10ns;
    localparam int  TURN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rb_valid = 1'b0, rb_write = 1'b0;
    logic [11:0] rb_addr = '0;
    logic [1:0]  rb_size = '0;
    logic [31:0] rb_wdata = '0;
    logic        rb_ready;
    logic [31:0] rb_rdata;
    logic        dn_req_valid, dn_req_is_cfg, dn_req_write;
    logic [31:0] dn_req_addr, dn_req_wdata;
    logic [3:0]  dn_req_be;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rsp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgio_window #(.TURN_CYCLES(TURN)) i_cfgio_window (
        .clk(clk), .rst_n(rst_n),
        .rb_valid(rb_valid), .rb_write(rb_write), .rb_addr(rb_addr),
        .rb_size(rb_size), .rb_wdata(rb_wdata),
        .rb_ready(rb_ready), .rb_rdata(rb_rdata),
        .dn_req_valid(dn_req_valid), .dn_req_is_cfg(dn_req_is_cfg),
        .dn_req_write(dn_req_write), .dn_req_addr(dn_req_addr),
        .dn_req_be(dn_req_be), .dn_req_wdata(dn_req_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata)
    );

    int checks = 0, fails = 0;

    // captured per access
    logic        got_req, early_ready;
    int          req_at, done_at;
    logic        c_cfg, c_wr;
    logic [31:0] c_addr, c_wdata, c_rdata;
    logic [3:0]  c_be;
    logic [31:0] rsp_word;

    // bench model of previous cycle kind
    logic        m_have = 1'b0, m_last_cfg = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lane_of(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'd0) return int'(off);
        if (sz == 2'd1) return int'(off & 2'b10);
        return 0;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        if (sz == 2'd0) return 32'hFF;
        if (sz == 2'd1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [3:0] be_of(input logic [1:0] sz, input int ln);
        if (sz == 2'd0) return 4'(1 << ln);
        if (sz == 2'd1) return 4'(3 << ln);
        return 4'hF;
    endfunction

    task automatic access(input logic w, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input int dly);
        int n = 0;
        @(negedge clk);
        rb_valid = 1'b1; rb_write = w; rb_addr = a; rb_size = sz; rb_wdata = wd;
        got_req = 1'b0; early_ready = 1'b0; req_at = -1; done_at = -1; c_rdata = 'x;
        while (n < 200) begin
            @(negedge clk); n++;
            if (rb_ready) begin
                c_rdata = rb_rdata; done_at = n;
                break;
            end
            if (dn_req_valid && !got_req) begin
                got_req = 1'b1; req_at = n;
                c_cfg = dn_req_is_cfg; c_wr = dn_req_write; c_addr = dn_req_addr;
                c_be = dn_req_be; c_wdata = dn_req_wdata;
                for (int i = 0; i < dly; i++) begin
                    @(negedge clk); n++;
                    if (rb_ready) early_ready = 1'b1;
                end
                dn_rsp_valid = 1'b1; dn_rsp_rdata = rsp_word;
                @(negedge clk); n++;
                dn_rsp_valid = 1'b0; dn_rsp_rdata = '0;
                if (rb_ready) begin
                    c_rdata = rb_rdata; done_at = n;
                end
                break;
            end
        end
        rb_valid = 1'b0;
        if (done_at < 0) begin
            checks++; fails++;
            $display("FAIL R9 access hung actual=%0d expected=<200", n);
        end
    endtask

    // window access with full checking against the model
    task automatic win_check(input logic is_cfg, input logic w, input logic [1:0] win_off,
                             input logic [1:0] sz, input logic [31:0] tgt, input logic [31:0] wd);
        int          ln;
        int          exp_at;
        logic [31:0] exp_addr;
        logic [1:0]  off;
        off = is_cfg ? win_off : tgt[1:0];
        ln  = lane_of(sz, off);
        exp_at = 1 + ((m_have && m_last_cfg != is_cfg) ? TURN : 0);
        exp_addr = is_cfg ? {8'h00, tgt[23:2], 2'b00} : {16'h0, tgt[15:0]};
        rsp_word = 32'h8C4A_2E61 ^ {tgt[7:0], 6'b0, sz, 7'b0, w, win_off, 6'b0};
        access(w, (is_cfg ? 12'h068 : 12'h06C) | {10'b0, win_off}, sz, wd, 2);
        m_have = 1'b1; m_last_cfg = is_cfg;
        chk(got_req && c_cfg == is_cfg, is_cfg ? "R3 kind" : "R4 kind", {31'b0, c_cfg}, {31'b0, is_cfg});
        chk(c_addr == exp_addr, is_cfg ? "R3 addr" : "R4 addr", c_addr, exp_addr);
        chk(c_be == be_of(sz, ln), is_cfg ? "R5 be" : "R6 be", {28'b0, c_be}, {28'b0, be_of(sz, ln)});
        chk(c_wr == w, "R7 dir", {31'b0, c_wr}, {31'b0, w});
        if (w) chk(c_wdata == ((wd & mask_of(sz)) << (8*ln)), "R7 wdata", c_wdata, (wd & mask_of(sz)) << (8*ln));
        if (!w) chk(c_rdata == ((rsp_word >> (8*ln)) & mask_of(sz)), "R8 rdata", c_rdata, (rsp_word >> (8*ln)) & mask_of(sz));
        else    chk(c_rdata == 32'h0, "R8 write rdata", c_rdata, 32'h0);
        chk(!early_ready, "R9 early ready", {31'b0, early_ready}, 32'h0);
        chk(req_at == exp_at, "R12 request timing", req_at, exp_at);
    endtask

    task automatic set_tgt(input logic [31:0] v);
        access(1'b1, 12'h064, 2'd2, v, 0);
        chk(!got_req && done_at == 1, "R2 addr write", done_at, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] tgt;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rb_ready == 1'b0, "R1 ready", {31'b0, rb_ready}, 0);
        chk(dn_req_valid == 1'b0, "R1 req", {31'b0, dn_req_valid}, 0);
        rst_n = 1'b1;
        access(1'b0, 12'h064, 2'd2, 0, 0);
        chk(c_rdata == 32'h0, "R1 addr reset", c_rdata, 0);

        // R2 readback
        set_tgt(32'h1234_5678);
        access(1'b0, 12'h064, 2'd2, 0, 0);
        chk(c_rdata == 32'h1234_5678 && !got_req && done_at == 1, "R2 readback", c_rdata, 32'h1234_5678);

        // R13 unmapped offsets
        access(1'b0, 12'h000, 2'd2, 0, 0);
        chk(c_rdata == 0 && !got_req && done_at == 1, "R13 unmapped read", c_rdata, 0);
        access(1'b1, 12'h070, 2'd2, 32'hFFFF_FFFF, 0);
        chk(!got_req && done_at == 1, "R13 unmapped write", {31'b0, got_req}, 0);
        access(1'b0, 12'h064, 2'd2, 0, 0);
        chk(c_rdata == 32'h1234_5678, "R13 no side effect", c_rdata, 32'h1234_5678);

        // Sweeps: alternating config and port windows
        for (int sz = 0; sz < 3; sz++) begin
            for (int lo = 0; lo < 4; lo++) begin
                for (int w = 0; w < 2; w++) begin
                    tgt = 32'hFF3C_9A44 | 32'(lo);
                    set_tgt(tgt);
                    win_check(1'b1, w[0], 2'(lo), 2'(sz), tgt, 32'hA1B2_C3D4 + 32'(lo));
                    // R6: window low bits deliberately differ from tgt low bits
                    tgt = 32'hDEAD_B7F0 | 32'(lo);
                    set_tgt(tgt);
                    win_check(1'b0, w[0], 2'(lo + 1), 2'(sz), tgt, 32'h5E6F_7081 ^ 32'(sz));
                    win_check(1'b0, w[0], 2'(lo + 2), 2'(sz), tgt, 32'h0F1E_2D3C);
                end
            end
        end

        // R10 reuse of the stored address
        tgt = 32'h0007_1820;
        set_tgt(tgt);
        win_check(1'b1, 1'b0, 2'd0, 2'd2, tgt, 0);
        win_check(1'b1, 1'b1, 2'd2, 2'd1, tgt, 32'hBEEF);
        chk(c_addr == 32'h0007_1820, "R10 reuse", c_addr, 32'h0007_1820);

        // R11 dummy read then write sequence
        tgt = 32'h0003_2A3C;
        set_tgt(tgt & 32'hFFFF_FF00);
        win_check(1'b1, 1'b0, 2'd0, 2'd2, tgt & 32'hFFFF_FF00, 0);
        chk(c_addr == 32'h0003_2A00, "R11 dummy read addr", c_addr, 32'h0003_2A00);
        set_tgt(tgt);
        win_check(1'b1, 1'b1, 2'd1, 2'd0, tgt, 32'h55);
        chk(c_addr == 32'h0003_2A3C && c_be == 4'b0010, "R11 write after dummy", c_addr, 32'h0003_2A3C);
        access(1'b0, 12'h064, 2'd2, 0, 0);
        chk(c_rdata == tgt, "R11 addr kept", c_rdata, tgt);

        // R9 long response delay
        rsp_word = 32'hCAFE_F00D;
        access(1'b0, 12'h068, 2'd2, 0, 9);
        chk(!early_ready && done_at == req_at + 10, "R9 wait for response", done_at, req_at + 10);
        chk(c_rdata == 32'hCAFE_F00D, "R8 long delay data", c_rdata, 32'hCAFE_F00D);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule